// File: doc/BRIEF.md
# Equivalent-Time Capture Bank Sequencer

This block steers a free-running stream of converter samples into a banked circular acquisition memory for equivalent-time capture. Once started, it writes samples without a break into the active bank, wrapping at the bank's end, while it waits for a trigger. A trigger counts only after a programmed amount of pretrigger history has been stored. When one is accepted, the block records where in the bank the first post-trigger sample goes and how many clocks have passed since the last stored sample. It then stores a programmed number of post-trigger samples and stops writing.

It then waits a bounded time for the fine trigger-time result from an external time interpolator. It files that result with the run's record, or marks the run invalid if the result does not arrive in time. In rotating mode, the next run begins at once in the following bank, so a set of runs can later be interleaved on a common time axis. In single-bank mode, capture halts after each run until software reads the bank and starts the block again.

A decimation setting stores only one of every N valid samples. Each bank has its own status code and its own record (pointer, gap, fine time, validity flag), all visible as flat output vectors.

Top module: `etacq_ctrl`

## Requirements
- R1: After reset, mem_we is 0, cur_bank is 0, every bank status is 0 (idle), and every record field and rec_ok bit is 0.
- R2: Samples are stored only after start. A sample stored in cycle c appears on mem_we/mem_addr/mem_wdata in cycle c+1. mem_addr is {bank, pointer}, and the pointer starts at 0 on each run and steps by one per store, wrapping modulo 2^AW. With cfg_decim = D, the first of every D+1 valid samples is stored, beginning with the first valid sample of the run.
- R3: A trigger pulse is accepted only while the active bank is armed and at least cfg_pre_depth samples have been stored in that run. Otherwise it is ignored: the status stays 1 and the records are unchanged.
- R4: On an accepted trigger, the bank status becomes 2 (triggered) in the next cycle. rec_ptr is set to the pointer of the first post-trigger store. rec_gap is set to the clocks since the run's last stored sample, and is 0 when a sample is stored in the trigger cycle.
- R5: Exactly cfg_post_cnt samples are stored from the trigger cycle on, counting a store in the trigger cycle itself. No further writes follow until the next run.
- R6: The first fine_valid pulse 1 to TMO cycles after the trigger cycle is filed. Once post capture completes, rec_fine takes that value, rec_ok becomes 1 and the status becomes 3 (done).
- R7: If no fine_valid pulse arrives within TMO cycles after the trigger, the run ends with rec_ok 0 and rec_fine 0, and the status becomes 3.
- R8: With cfg_single 0, the next run starts right after a run ends, in bank (cur_bank+1) mod NBANK, with status 1, pointer 0 and the pretrigger count reset. Earlier banks keep their records and their status 3.
- R9: With cfg_single 1, the block stops after a run in bank 0 with no further writes. A start pulse then sets bank 0 to status 1, sets all other banks to 0, and begins a new run in bank 0.
- R10: A start pulse while a run is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_single | input | 1 | 1 = halt after each run in bank 0; 0 = rotate over banks |
| cfg_decim | input | DEC_W | Store one of every cfg_decim+1 valid samples |
| cfg_pre_depth | input | AW | Stores needed in a run before a trigger counts |
| cfg_post_cnt | input | AW | Samples stored from the trigger on |
| start | input | 1 | Start pulse, honoured only when halted |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DW | Sample value |
| trig | input | 1 | Trigger pulse |
| fine_valid | input | 1 | Fine-time result strobe |
| fine_time | input | FT_W | Fine-time result |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | BW+AW | Memory address {bank, pointer} |
| mem_wdata | output | DW | Memory write data |
| cur_bank | output | BW | Bank in use |
| bank_state | output | 2*NBANK | Per-bank status: 0 idle, 1 armed, 2 triggered, 3 done |
| rec_ptr | output | AW*NBANK | Per-bank first post-trigger pointer |
| rec_gap | output | GAP_W*NBANK | Per-bank clocks from last store to trigger |
| rec_fine | output | FT_W*NBANK | Per-bank fine time |
| rec_ok | output | NBANK | Per-bank fine time received in time |

## Verification
A write is due one cycle after the cycle whose sample it stores. A triggered status is due one cycle after the trigger cycle. The done status and the run's record fields are due one cycle after the first wait cycle that follows the last post-trigger store, if the fine result is already held; otherwise they are due after the fine pulse or the timeout. The bench drives inputs just after a rising edge and samples outputs in the following cycle, before the next edge, so a check placed at capture cycle j sees the effect of the inputs of cycle j-1. Directed cases check these due cycles exactly; the vector runs wait a bound long enough for the latest due cycle and then compare records and write counts.

// File: rtl/etacq_pkg.sv
package etacq_pkg;
  typedef enum logic [1:0] {
    ACQ_HALT = 2'd0,
    ACQ_PRE  = 2'd1,
    ACQ_POST = 2'd2,
    ACQ_WAIT = 2'd3
  } acq_state_e;

  localparam logic [1:0] BK_IDLE  = 2'd0;
  localparam logic [1:0] BK_ARMED = 2'd1;
  localparam logic [1:0] BK_TRIG  = 2'd2;
  localparam logic [1:0] BK_DONE  = 2'd3;
endpackage

// File: rtl/etacq_decim.sv
module etacq_decim #(
  parameter int DEC_W = 4,
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic             smp_valid,
  input  logic [DEC_W-1:0] cfg_decim,
  output logic             store,
  output logic [GAP_W-1:0] gap
);
  localparam logic [GAP_W-1:0] GAP_MAX = '1;

  logic [DEC_W-1:0] ph_q, ph_n;
  logic [GAP_W-1:0] gap_q, gap_n;
  logic             ph_en, gap_en;

  always_comb begin
    store  = run & smp_valid & (ph_q == '0);
    gap    = store ? '0 : gap_q;
    ph_en  = restart | (run & smp_valid);
    if (restart)               ph_n = '0;
    else if (ph_q >= cfg_decim) ph_n = '0;
    else                       ph_n = ph_q + 1'b1;
    gap_en = restart | run;
    if (restart)               gap_n = '0;
    else if (store)            gap_n = GAP_W'(1);
    else if (gap_q == GAP_MAX) gap_n = gap_q;
    else                       gap_n = gap_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      gap_q <= '0;
    end else begin
      if (ph_en)  ph_q  <= ph_n;
      if (gap_en) gap_q <= gap_n;
    end
  end
endmodule

// File: rtl/etacq_wptr.sv
module etacq_wptr #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          store,
  input  logic          post_en,
  input  logic [AW-1:0] cfg_pre_depth,
  input  logic [AW-1:0] cfg_post_cnt,
  output logic [AW-1:0] wr_ptr,
  output logic          pre_full,
  output logic          post_last
);
  localparam logic [AW-1:0] PRE_MAX = '1;

  logic [AW-1:0] ptr_q, ptr_n, pre_q, pre_n;
  logic [AW:0]   post_q, post_n, post_inc;
  logic          ptr_en, pre_en, post_cen;

  always_comb begin
    wr_ptr    = ptr_q;
    pre_full  = (pre_q >= cfg_pre_depth);
    post_inc  = post_q + 1'b1;
    post_last = store & post_en & (post_inc >= {1'b0, cfg_post_cnt});

    ptr_en = restart | store;
    ptr_n  = restart ? '0 : ptr_q + 1'b1;

    pre_en = restart | (store & (pre_q != PRE_MAX));
    pre_n  = restart ? '0 : pre_q + 1'b1;

    post_cen = restart | (store & post_en);
    post_n   = restart ? '0 : post_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      pre_q  <= '0;
      post_q <= '0;
    end else begin
      if (ptr_en)   ptr_q  <= ptr_n;
      if (pre_en)   pre_q  <= pre_n;
      if (post_cen) post_q <= post_n;
    end
  end
endmodule

// File: rtl/etacq_recs.sv
module etacq_recs
  import etacq_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int AW    = 6,
  parameter int GAP_W = 8,
  parameter int FT_W  = 10,
  parameter int BW    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_all,
  input  logic               arm_set,
  input  logic [BW-1:0]      arm_bank,
  input  logic               trig_set,
  input  logic               done_set,
  input  logic [BW-1:0]      sel_bank,
  input  logic [AW-1:0]      t_ptr,
  input  logic [GAP_W-1:0]   t_gap,
  input  logic [FT_W-1:0]    d_fine,
  input  logic               d_ok,
  output logic [2*NBANK-1:0]     bank_state,
  output logic [AW*NBANK-1:0]    rec_ptr,
  output logic [GAP_W*NBANK-1:0] rec_gap,
  output logic [FT_W*NBANK-1:0]  rec_fine,
  output logic [NBANK-1:0]       rec_ok
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic [BW-1:0] BIDX = BW'(b);

    logic [1:0]       st_q, st_n;
    logic [AW-1:0]    ptr_q;
    logic [GAP_W-1:0] gap_q;
    logic [FT_W-1:0]  fine_q;
    logic             ok_q;
    logic             st_en, t_en, d_en;

    always_comb begin
      t_en  = trig_set & (sel_bank == BIDX);
      d_en  = done_set & (sel_bank == BIDX);
      st_en = clr_all | t_en | d_en | (arm_set & (arm_bank == BIDX));
      if (clr_all)     st_n = (b == 0) ? BK_ARMED : BK_IDLE;
      else if (d_en)   st_n = BK_DONE;
      else if (t_en)   st_n = BK_TRIG;
      else             st_n = BK_ARMED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q   <= BK_IDLE;
        ptr_q  <= '0;
        gap_q  <= '0;
        fine_q <= '0;
        ok_q   <= 1'b0;
      end else begin
        if (st_en) st_q <= st_n;
        if (t_en) begin
          ptr_q <= t_ptr;
          gap_q <= t_gap;
        end
        if (d_en) begin
          fine_q <= d_fine;
          ok_q   <= d_ok;
        end
      end
    end

    assign bank_state[2*b +: 2]      = st_q;
    assign rec_ptr[AW*b +: AW]       = ptr_q;
    assign rec_gap[GAP_W*b +: GAP_W] = gap_q;
    assign rec_fine[FT_W*b +: FT_W]  = fine_q;
    assign rec_ok[b]                 = ok_q;
  end
endmodule

// File: rtl/etacq_ctrl.sv
module etacq_ctrl
  import etacq_pkg::*;
#(
  parameter int DW    = 12,
  parameter int NBANK = 4,
  parameter int AW    = 6,
  parameter int FT_W  = 10,
  parameter int GAP_W = 8,
  parameter int DEC_W = 4,
  parameter int TMO   = 20,
  localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_single,
  input  logic [DEC_W-1:0]       cfg_decim,
  input  logic [AW-1:0]          cfg_pre_depth,
  input  logic [AW-1:0]          cfg_post_cnt,
  input  logic                   start,
  input  logic                   smp_valid,
  input  logic [DW-1:0]          smp_data,
  input  logic                   trig,
  input  logic                   fine_valid,
  input  logic [FT_W-1:0]        fine_time,
  output logic                   mem_we,
  output logic [BW+AW-1:0]       mem_addr,
  output logic [DW-1:0]          mem_wdata,
  output logic [BW-1:0]          cur_bank,
  output logic [2*NBANK-1:0]     bank_state,
  output logic [AW*NBANK-1:0]    rec_ptr,
  output logic [GAP_W*NBANK-1:0] rec_gap,
  output logic [FT_W*NBANK-1:0]  rec_fine,
  output logic [NBANK-1:0]       rec_ok
);
  localparam int TW = $clog2(TMO + 1);
  localparam logic [TW-1:0] TMO_V = TW'(TMO);
  localparam logic [BW-1:0] LAST_BANK = BW'(NBANK - 1);

  acq_state_e       st_q, st_n;
  logic [BW-1:0]    bank_q, bank_n, bank_inc;
  logic [TW-1:0]    tmr_q, tmr_n;
  logic             tmr_en;
  logic             fhave_q, fhave_n, fhave_en;
  logic [FT_W-1:0]  fine_q;
  logic             fine_take, fine_now;

  logic             run, in_post, in_tail, trig_acc, fin, restart, halt_start;
  logic             store, pre_full, post_last;
  logic [GAP_W-1:0] gap;
  logic [AW-1:0]    wr_ptr;
  logic [FT_W-1:0]  d_fine;
  logic             d_ok;

  // capture-path helpers
  etacq_decim #(.DEC_W(DEC_W), .GAP_W(GAP_W)) u_decim (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .run       (run),
    .smp_valid (smp_valid),
    .cfg_decim (cfg_decim),
    .store     (store),
    .gap       (gap)
  );

  etacq_wptr #(.AW(AW)) u_wptr (
    .clk           (clk),
    .rst_n         (rst_n),
    .restart       (restart),
    .store         (store),
    .post_en       (trig_acc | in_post),
    .cfg_pre_depth (cfg_pre_depth),
    .cfg_post_cnt  (cfg_post_cnt),
    .wr_ptr        (wr_ptr),
    .pre_full      (pre_full),
    .post_last     (post_last)
  );

  etacq_recs #(
    .NBANK(NBANK), .AW(AW), .GAP_W(GAP_W), .FT_W(FT_W), .BW(BW)
  ) u_recs (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_all    (halt_start),
    .arm_set    (fin & ~cfg_single),
    .arm_bank   (bank_inc),
    .trig_set   (trig_acc),
    .done_set   (fin),
    .sel_bank   (bank_q),
    .t_ptr      (wr_ptr),
    .t_gap      (gap),
    .d_fine     (d_fine),
    .d_ok       (d_ok),
    .bank_state (bank_state),
    .rec_ptr    (rec_ptr),
    .rec_gap    (rec_gap),
    .rec_fine   (rec_fine),
    .rec_ok     (rec_ok)
  );

  // run control decode
  always_comb begin
    run        = (st_q == ACQ_PRE) | (st_q == ACQ_POST);
    in_post    = (st_q == ACQ_POST);
    in_tail    = (st_q == ACQ_POST) | (st_q == ACQ_WAIT);
    halt_start = (st_q == ACQ_HALT) & start;
    trig_acc   = (st_q == ACQ_PRE) & trig & pre_full;
    fine_now   = fine_valid & (tmr_q < TMO_V);
    fine_take  = in_tail & fine_now & ~fhave_q;
    fin        = (st_q == ACQ_WAIT) & (fhave_q | fine_now | (tmr_q >= TMO_V));
    restart    = halt_start | (fin & ~cfg_single);
    bank_inc   = (bank_q == LAST_BANK) ? '0 : bank_q + 1'b1;
    d_ok       = fhave_q | fine_now;
    if (fhave_q)       d_fine = fine_q;
    else if (fine_now) d_fine = fine_time;
    else               d_fine = '0;
  end

  // next state
  always_comb begin
    st_n   = st_q;
    bank_n = bank_q;
    unique case (st_q)
      ACQ_HALT: if (start) begin
        st_n   = ACQ_PRE;
        bank_n = '0;
      end
      ACQ_PRE:  if (trig_acc) st_n = post_last ? ACQ_WAIT : ACQ_POST;
      ACQ_POST: if (post_last) st_n = ACQ_WAIT;
      ACQ_WAIT: if (fin) begin
        if (cfg_single) st_n = ACQ_HALT;
        else begin
          st_n   = ACQ_PRE;
          bank_n = bank_inc;
        end
      end
      default:  st_n = ACQ_HALT;
    endcase

    tmr_en   = trig_acc | in_tail;
    if (trig_acc)             tmr_n = '0;
    else if (tmr_q >= TMO_V)  tmr_n = tmr_q;
    else                      tmr_n = tmr_q + 1'b1;

    fhave_en = trig_acc | fine_take;
    fhave_n  = ~trig_acc;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ACQ_HALT;
      bank_q    <= '0;
      tmr_q     <= '0;
      fhave_q   <= 1'b0;
      fine_q    <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      st_q   <= st_n;
      bank_q <= bank_n;
      if (tmr_en)    tmr_q   <= tmr_n;
      if (fhave_en)  fhave_q <= fhave_n;
      if (fine_take) fine_q  <= fine_time;
      mem_we <= store;
      if (store) begin
        mem_addr  <= {bank_q, wr_ptr};
        mem_wdata <= smp_data;
      end
    end
  end

  assign cur_bank = bank_q;
endmodule

// File: rtl/etacq_ctrl_chk.sv
module etacq_ctrl_chk #(
  parameter int NBANK = 4,
  parameter int AW    = 6,
  parameter int BW    = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               trig,
  input logic               cfg_single,
  input logic               mem_we,
  input logic [BW+AW-1:0]   mem_addr,
  input logic [BW-1:0]      cur_bank,
  input logic [2*NBANK-1:0] bank_state
);
  logic [NBANK-1:0] live;

  always_comb begin
    for (int b = 0; b < NBANK; b++)
      live[b] = (bank_state[2*b +: 2] == 2'd1) | (bank_state[2*b +: 2] == 2'd2);
  end

  // R2: back-to-back writes in one bank use consecutive pointers
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we) && mem_addr[BW+AW-1:AW] == $past(mem_addr[BW+AW-1:AW]))
    |-> mem_addr[AW-1:0] == $past(mem_addr[AW-1:0]) + 1'b1);

  // R5: a write needs a bank that was armed or triggered
  a_r5_write_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(|live));

  // R8: at most one bank is live at a time
  a_r8_single_live: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(live));

  // R9: single-bank mode never leaves bank 0
  a_r9_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_single && $past(cfg_single) && $past(cur_bank) == '0) |-> cur_bank == '0);

  for (genvar b = 0; b < NBANK; b++) begin : g_bk
    // R3: a bank goes from armed to triggered only on a trigger pulse
    a_r3_trig_pin: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_state[2*b +: 2] == 2'd2 && $past(bank_state[2*b +: 2]) == 2'd1) |-> $past(trig));
    // R6: done is entered only from triggered
    a_r6_done_from_trig: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_state[2*b +: 2] == 2'd3 && $past(bank_state[2*b +: 2]) != 2'd3)
      |-> $past(bank_state[2*b +: 2]) == 2'd2);
  end
endmodule

bind etacq_ctrl etacq_ctrl_chk #(.NBANK(NBANK), .AW(AW), .BW(BW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trig       (trig),
  .cfg_single (cfg_single),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .cur_bank   (cur_bank),
  .bank_state (bank_state)
);

// File: tb/etacq_ctrl_bench.sv
module etacq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12, NB = 4, AW = 6, FT_W = 10, GAP_W = 8, DEC_W = 4, TMO = 20;
  localparam int BW = 2;
  localparam int NV = 6;
  // fields: decim[31:28] pre[27:22] post[21:16] trig cycle[15:8] fine delay[7:0] (0 = none)
  localparam logic [31:0] VEC [NV] = '{
    {4'd0, 6'd4,  6'd8,  8'd10, 8'd3},
    {4'd2, 6'd3,  6'd5,  8'd11, 8'd25},
    {4'd1, 6'd2,  6'd3,  8'd7,  8'd1},
    {4'd0, 6'd0,  6'd1,  8'd0,  8'd20},
    {4'd3, 6'd1,  6'd4,  8'd4,  8'd0},
    {4'd0, 6'd50, 6'd30, 8'd60, 8'd5}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_single;
  logic [DEC_W-1:0] cfg_decim;
  logic [AW-1:0] cfg_pre_depth, cfg_post_cnt;
  logic start, smp_valid, trig, fine_valid;
  logic [DW-1:0] smp_data;
  logic [FT_W-1:0] fine_time;
  logic mem_we;
  logic [BW+AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [BW-1:0] cur_bank;
  logic [2*NB-1:0] bank_state;
  logic [AW*NB-1:0] rec_ptr;
  logic [GAP_W*NB-1:0] rec_gap;
  logic [FT_W*NB-1:0] rec_fine;
  logic [NB-1:0] rec_ok;

  int nchk = 0, nfail = 0, nwr = 0;
  logic mon_en = 1'b0, mon_clr = 1'b0;
  logic [AW-1:0] exp_ptr = '0;
  bit ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  etacq_ctrl #(.DW(DW), .NBANK(NB), .AW(AW), .FT_W(FT_W), .GAP_W(GAP_W),
               .DEC_W(DEC_W), .TMO(TMO)) u_etacq_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_single(cfg_single), .cfg_decim(cfg_decim),
    .cfg_pre_depth(cfg_pre_depth), .cfg_post_cnt(cfg_post_cnt), .start(start),
    .smp_valid(smp_valid), .smp_data(smp_data), .trig(trig),
    .fine_valid(fine_valid), .fine_time(fine_time), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cur_bank(cur_bank),
    .bank_state(bank_state), .rec_ptr(rec_ptr), .rec_gap(rec_gap),
    .rec_fine(rec_fine), .rec_ok(rec_ok));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // write monitor: counts writes and checks the pointer sequence (R2)
  always @(negedge clk) begin
    if (mon_clr) begin
      exp_ptr = '0;
      nwr     = 0;
    end else if (rst_n && mem_we) begin
      nwr++;
      if (mon_en) begin
        chk(mem_addr == {2'd0, exp_ptr}, "R2 write address", 32'(mem_addr), 32'({2'd0, exp_ptr}));
        exp_ptr = exp_ptr + 1'b1;
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_start();
    start = 1'b1; mon_clr = 1'b1;
    step();
    start = 1'b0; mon_clr = 1'b0;
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  task automatic run_multi(input int j0, input int tj);
    logic [BW-1:0] sb;
    sb = cur_bank;
    for (int j = j0; j < 80; j++) begin
      trig = (j == tj);
      fine_valid = (j == tj + 1);
      fine_time = FT_W'(j + 7);
      step();
      if (cur_bank != sb) break;
    end
    trig = 1'b0; fine_valid = 1'b0;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!ended) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_single = 1'b1; cfg_decim = '0; cfg_pre_depth = '0;
    cfg_post_cnt = 6'd1; start = 1'b0; smp_valid = 1'b0; smp_data = '0;
    trig = 1'b0; fine_valid = 1'b0; fine_time = '0;
    repeat (3) step();
    // R1 reset state
    chk(mem_we == 1'b0, "R1 mem_we", 32'(mem_we), 0);
    chk(cur_bank == '0, "R1 cur_bank", 32'(cur_bank), 0);
    chk(bank_state == '0, "R1 bank_state", 32'(bank_state), 0);
    chk(rec_ptr == '0 && rec_ok == '0 && rec_gap == '0 && rec_fine == '0,
        "R1 records", 32'(rec_ptr), 0);
    rst_n = 1'b1;
    step();

    // R2/R4/R6 exact timing with decimation by 2
    smp_valid = 1'b1; cfg_decim = 4'd1; cfg_pre_depth = 6'd3; cfg_post_cnt = 6'd2;
    mon_en = 1'b1;
    do_start();
    for (int j = 0; j < 20; j++) begin
      if (j == 1) begin
        chk(mem_we && mem_addr == 8'd0 && mem_wdata == 12'h100, "R2 first store",
            32'({mem_we, mem_addr, mem_wdata}), 32'({1'b1, 8'd0, 12'h100}));
      end
      if (j == 2) chk(mem_we == 1'b0, "R2 decimated slot", 32'(mem_we), 0);
      if (j == 3) chk(mem_we && mem_addr == 8'd1 && mem_wdata == 12'h102, "R2 second store",
            32'({mem_we, mem_addr, mem_wdata}), 32'({1'b1, 8'd1, 12'h102}));
      if (j == 9)  chk(bank_state[1:0] == 2'd2, "R4 triggered next cycle", 32'(bank_state[1:0]), 2);
      if (j == 11) chk(bank_state[1:0] == 2'd2, "R6 not done before wait", 32'(bank_state[1:0]), 2);
      if (j == 12) chk(bank_state[1:0] == 2'd3, "R6 done", 32'(bank_state[1:0]), 3);
      smp_data = DW'(12'h100 + j);
      trig = (j == 8);
      fine_valid = (j == 9);
      fine_time = 10'h155;
      step();
    end
    trig = 1'b0; fine_valid = 1'b0;
    chk(rec_ptr[AW-1:0] == 6'd4, "R4 pointer", 32'(rec_ptr[AW-1:0]), 4);
    chk(rec_gap[GAP_W-1:0] == 8'd0, "R4 gap", 32'(rec_gap[GAP_W-1:0]), 0);
    chk(rec_fine[FT_W-1:0] == 10'h155 && rec_ok[0], "R6 fine", 32'(rec_fine[FT_W-1:0]), 32'h155);

    // R3 early trigger ignored, R10 start ignored mid-run
    cfg_decim = 4'd0; cfg_pre_depth = 6'd10; cfg_post_cnt = 6'd2;
    do_start();
    for (int j = 0; j < 22; j++) begin
      if (j == 7) begin
        chk(bank_state[1:0] == 2'd1, "R3 early trigger ignored", 32'(bank_state[1:0]), 1);
        chk(rec_ptr[AW-1:0] == 6'd4, "R3 record untouched", 32'(rec_ptr[AW-1:0]), 4);
      end
      if (j == 16) chk(bank_state[1:0] == 2'd2, "R4 accepted trigger", 32'(bank_state[1:0]), 2);
      if (j == 17) chk(bank_state[1:0] == 2'd2 && cur_bank == '0, "R10 start ignored",
                       32'(bank_state), 32'h02);
      if (j == 18) chk(bank_state == 8'h03, "R6 done after fine", 32'(bank_state), 32'h03);
      trig = (j == 5) || (j == 15);
      start = (j == 16);
      fine_valid = (j == 17);
      fine_time = 10'h0AA;
      step();
    end
    trig = 1'b0; start = 1'b0; fine_valid = 1'b0;
    chk(rec_ptr[AW-1:0] == 6'd15, "R3 pointer after late trigger", 32'(rec_ptr[AW-1:0]), 15);

    // vector table, single-bank mode
    for (int v = 0; v < NV; v++) begin
      int d, pre, post, t, f, len, nb4, exp_wr, wr_end;
      logic ok;
      d = int'(VEC[v][31:28]); pre = int'(VEC[v][27:22]); post = int'(VEC[v][21:16]);
      t = int'(VEC[v][15:8]); f = int'(VEC[v][7:0]);
      nb4 = (t + d) / (d + 1);
      exp_wr = nb4 + post;
      ok = (f != 0) && (f <= TMO);
      len = t + post * (d + 1) + TMO + 8;
      cfg_decim = DEC_W'(d); cfg_pre_depth = AW'(pre); cfg_post_cnt = AW'(post);
      do_start();
      chk(bank_state == 8'h01, "R9 restart arms bank 0 only", 32'(bank_state), 1);
      for (int j = 0; j < len; j++) begin
        trig = (j == t);
        fine_valid = (f != 0) && (j == t + f);
        fine_time = FT_W'(32 + v);
        step();
      end
      trig = 1'b0; fine_valid = 1'b0;
      chk(bank_state[1:0] == 2'd3, "R6 R7 done status", 32'(bank_state[1:0]), 3);
      chk(rec_ptr[AW-1:0] == AW'(nb4), "R4 vector pointer", 32'(rec_ptr[AW-1:0]), 32'(nb4 % 64));
      chk(rec_gap[GAP_W-1:0] == GAP_W'(t % (d + 1)), "R4 vector gap",
          32'(rec_gap[GAP_W-1:0]), 32'(t % (d + 1)));
      chk(rec_ok[0] == ok, "R7 validity", 32'(rec_ok[0]), 32'(ok));
      chk(rec_fine[FT_W-1:0] == (ok ? FT_W'(32 + v) : '0), "R7 fine value",
          32'(rec_fine[FT_W-1:0]), ok ? 32'(32 + v) : 0);
      chk(nwr == exp_wr, "R5 write count", 32'(nwr), 32'(exp_wr));
      wr_end = nwr;
      repeat (5) step();
      chk(nwr == wr_end && cur_bank == '0, "R9 halted after run", 32'(nwr), 32'(wr_end));
    end

    // R8 rotating mode
    mon_en = 1'b0; cfg_single = 1'b0;
    cfg_decim = 4'd0; cfg_pre_depth = 6'd2; cfg_post_cnt = 6'd3;
    do_start();
    run_multi(0, 4);
    chk(cur_bank == 2'd1 && bank_state == 8'h07, "R8 advance to bank 1",
        32'(bank_state), 32'h07);
    step();
    chk(mem_we && mem_addr == {2'd1, 6'd0}, "R8 new bank pointer 0",
        32'(mem_addr), 32'h40);
    trig = 1'b1; step(); trig = 1'b0; step();
    chk(bank_state[3:2] == 2'd1, "R8 pretrigger count restarts", 32'(bank_state[3:2]), 1);
    run_multi(3, 4);
    chk(rec_ptr[2*AW-1:AW] == 6'd4 && rec_ptr[AW-1:0] == 6'd4, "R8 bank 0 record kept",
        32'(rec_ptr[2*AW-1:0]), 32'h104);
    run_multi(0, 5);
    run_multi(0, 6);
    chk(cur_bank == 2'd0 && bank_state == 8'hFD, "R8 wrap to bank 0", 32'(bank_state), 32'hFD);
    chk(rec_ptr[4*AW-1:2*AW] == {6'd6, 6'd5} && rec_ok == 4'hF, "R8 records banks 2 and 3",
        32'(rec_ptr[4*AW-1:2*AW]), 32'h185);

    ended = 1;
    report();
    $finish;
  end
endmodule